// File: doc/BRIEF.md
# Multiprocessor Distributed Interrupt Controller

This block collects a parameterised set of hardware interrupt lines and hands them out to four processor cores. Each line carries a programmable priority, a four-bit set of target cores, an enable and a three-way status: idle, pending or active. A rising edge on an enabled, idle line makes it pending. Every core then sees the most urgent pending interrupt that is routed to it, provided that core's interface is enabled and the interrupt clears the core's priority threshold.

A core takes an interrupt by pulsing its acknowledge. The ID returned to it is registered, and the interrupt becomes active, so no other core is offered it. The core ends handling by pulsing end-of-interrupt together with the same ID. Software on any core can also raise one of sixteen interprocessor interrupts toward any subset of cores through the same write port that configures sources and cores.

Top module: `irq_dist`

## Requirements
- R1: After reset every source is idle and disabled, every core interface is disabled with threshold 0, no IPI is pending, `cpu_irq` is 0 and every `cpu_ack_id` field reads 1023.
- R2: A rising edge on `irq_in[i]` makes source i pending only while it is idle and enabled. An edge seen while the source is disabled is dropped, and enabling the source later does not raise it.
- R3: Among the candidates for a core, the lower priority value wins. On equal priority, the lower ID wins.
- R4: Bit c of a source's target field (bit 0 is core 0) decides whether core c is offered that source.
- R5: An acknowledge from a core that is signalling an interrupt loads that interrupt's ID into the core's `cpu_ack_id` field one clock later and makes a hardware source active. An active source is offered to no core.
- R6: A pulse on `cpu_eoi[c]` with an ID in `cpu_eoi_id` returns that active source to idle, so a later edge can make it pending again. An edge that arrives while the source is pending or active is dropped.
- R7: An acknowledge from a core whose `cpu_irq` bit is low returns the spurious ID 1023 and changes no state.
- R8: A core is signalled only when its interface enable is set and the winning priority is strictly below the core's threshold, so a threshold of 0 masks everything.
- R9: A write of kind 2 sets IPI `cfg_wdata[3:0]` pending on every core whose bit in `cfg_wdata[7:4]` is set. An IPI has ID 0 to 15 and priority 0. Acknowledging it clears it only on the acknowledging core.
- R10: When several cores acknowledge the same hardware source in one cycle, the lowest-numbered core gets its ID and the others get 1023.
- R11: Hardware line i has interrupt ID 16 + i.
- R12: Writes of kind 0 set source `cfg_idx` to priority `[3:0]`, targets `[7:4]` and enable `[8]`. Writes of kind 1 set core `cfg_idx` to threshold `[3:0]` and interface enable `[4]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Hardware interrupt lines, rising-edge triggered |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 source setup, 1 core setup, 2 raise IPI |
| cfg_idx | input | 8 | Source or core index |
| cfg_wdata | input | 9 | Write data |
| cpu_ack | input | 4 | Acknowledge pulse per core |
| cpu_eoi | input | 4 | End-of-interrupt pulse per core |
| cpu_eoi_id | input | 40 | ID being completed, 10 bits per core |
| cpu_irq | output | 4 | Interrupt request per core |
| cpu_ack_id | output | 40 | ID returned by the last acknowledge, 10 bits per core |

## Verification
The bench targets equal-priority ties, where a design that compares with less-or-equal would hand out the higher ID first. It checks a threshold exactly equal to the source priority, which must stay silent; an off-by-one comparison would interrupt the core. It also raises a line again while the source is active, which a design without the status check would turn into a second delivery. Two cores acknowledge the same source in one cycle, which a design with no claim ordering would deliver twice. A one-core IPI acknowledge tests whether a design wrongly clears the IPI on every listed core.

// File: rtl/irq_dist.sv
module irq_dist #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_kind,
  input  logic [7:0]         cfg_idx,
  input  logic [8:0]         cfg_wdata,
  input  logic [3:0]         cpu_ack,
  input  logic [3:0]         cpu_eoi,
  input  logic [39:0]        cpu_eoi_id,
  output logic [3:0]         cpu_irq,
  output logic [39:0]        cpu_ack_id
);
  localparam int CPUS = 4;
  localparam int IDW  = 10;
  localparam int PW   = 4;
  localparam int NIPI = 16;
  localparam int SW   = NUM_SRC > 1 ? $clog2(NUM_SRC) : 1;
  localparam logic [IDW-1:0] SPUR = 10'd1023;
  localparam logic [PW-1:0]  IPI_PRIO = '0;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_PEND = 2'd1, S_ACT = 2'd2} st_t;

  st_t [NUM_SRC-1:0]             st;
  logic [NUM_SRC-1:0][PW-1:0]    prio;
  logic [NUM_SRC-1:0][CPUS-1:0]  tgt;
  logic [NUM_SRC-1:0]            src_en;
  logic [NUM_SRC-1:0]            irq_q;
  logic [CPUS-1:0][PW-1:0]       pmask;
  logic [CPUS-1:0]               cpu_en;
  logic [CPUS-1:0][NIPI-1:0]     ipi_pend;

  logic [CPUS-1:0]               found, pres, pres_hw, grant;
  logic [CPUS-1:0][PW-1:0]       pres_prio;
  logic [CPUS-1:0][IDW-1:0]      pres_id;
  logic [CPUS-1:0][SW-1:0]       pres_src;
  logic [NUM_SRC-1:0]            claim;

  always_comb begin
    for (int c = 0; c < CPUS; c++) begin
      found[c]     = 1'b0;
      pres_prio[c] = '1;
      pres_id[c]   = SPUR;
      pres_hw[c]   = 1'b0;
      pres_src[c]  = '0;
      for (int i = 0; i < NIPI; i++)
        if (ipi_pend[c][i] && (!found[c] || IPI_PRIO < pres_prio[c])) begin
          found[c]     = 1'b1;
          pres_prio[c] = IPI_PRIO;
          pres_id[c]   = IDW'(i);
        end
      for (int s = 0; s < NUM_SRC; s++)
        if (src_en[s] && st[s] == S_PEND && tgt[s][c] &&
            (!found[c] || prio[s] < pres_prio[c])) begin
          found[c]     = 1'b1;
          pres_prio[c] = prio[s];
          pres_id[c]   = IDW'(s + NIPI);
          pres_hw[c]   = 1'b1;
          pres_src[c]  = SW'(s);
        end
      pres[c] = found[c] && cpu_en[c] && (pres_prio[c] < pmask[c]);
    end
  end

  assign cpu_irq = pres;

  always_comb begin
    claim = '0;
    grant = '0;
    for (int c = 0; c < CPUS; c++)
      if (cpu_ack[c] && pres[c]) begin
        if (!pres_hw[c]) grant[c] = 1'b1;
        else if (!claim[pres_src[c]]) begin
          grant[c] = 1'b1;
          claim[pres_src[c]] = 1'b1;
        end
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= {NUM_SRC{S_IDLE}};
      prio       <= '0;
      tgt        <= '0;
      src_en     <= '0;
      irq_q      <= '0;
      pmask      <= '0;
      cpu_en     <= '0;
      ipi_pend   <= '0;
      cpu_ack_id <= {CPUS{SPUR}};
    end else begin
      irq_q <= irq_in;
      if (cfg_we && cfg_kind == 2'd0)
        for (int s = 0; s < NUM_SRC; s++)
          if (cfg_idx == 8'(s)) begin
            prio[s]   <= cfg_wdata[3:0];
            tgt[s]    <= cfg_wdata[7:4];
            src_en[s] <= cfg_wdata[8];
          end
      if (cfg_we && cfg_kind == 2'd1)
        for (int c = 0; c < CPUS; c++)
          if (cfg_idx == 8'(c)) begin
            pmask[c]  <= cfg_wdata[3:0];
            cpu_en[c] <= cfg_wdata[4];
          end
      for (int s = 0; s < NUM_SRC; s++)
        if (irq_in[s] && !irq_q[s] && src_en[s] && st[s] == S_IDLE)
          st[s] <= S_PEND;
      for (int c = 0; c < CPUS; c++) begin
        if (cpu_ack[c])
          cpu_ack_id[c*IDW +: IDW] <= grant[c] ? pres_id[c] : SPUR;
        if (grant[c]) begin
          if (pres_hw[c]) st[pres_src[c]] <= S_ACT;
          else ipi_pend[c][pres_id[c][3:0]] <= 1'b0;
        end
        for (int s = 0; s < NUM_SRC; s++)
          if (cpu_eoi[c] && cpu_eoi_id[c*IDW +: IDW] == IDW'(s + NIPI) &&
              st[s] == S_ACT)
            st[s] <= S_IDLE;
      end
      if (cfg_we && cfg_kind == 2'd2)
        for (int c = 0; c < CPUS; c++)
          if (cfg_wdata[4+c]) ipi_pend[c][cfg_wdata[3:0]] <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk #(
  parameter int NUM_SRC = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [3:0]                 cpu_irq,
  input logic [3:0]                 cpu_ack,
  input logic [39:0]                cpu_ack_id,
  input logic [3:0]                 cpu_en,
  input logic [3:0][3:0]            pmask,
  input logic [NUM_SRC-1:0][1:0]    st,
  input logic [3:0][9:0]            pres_id
);
  for (genvar c = 0; c < 4; c++) begin : g_cpu
    assert_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack[c] && !cpu_irq[c] |=> cpu_ack_id[c*10 +: 10] == 10'd1023);
    assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] |-> cpu_en[c] && pmask[c] != 4'd0);
  end

  assert_ack_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack[0] && cpu_irq[0] |=> cpu_ack_id[9:0] == $past(pres_id[0]));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assert_no_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      st[s] == 2'd0 |=> st[s] != 2'd2);
    assert_legal_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
      st[s] != 2'd3);
  end
endmodule

bind irq_dist irq_dist_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .cpu_ack(cpu_ack),
  .cpu_ack_id(cpu_ack_id), .cpu_en(cpu_en), .pmask(pmask),
  .st(st), .pres_id(pres_id)
);

// File: tb/tb_irq_dist.sv
module tb_irq_dist;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;

  logic          clk = 0, rst_n = 0;
  logic [NS-1:0] irq_in = '0;
  logic          cfg_we = 0;
  logic [1:0]    cfg_kind = '0;
  logic [7:0]    cfg_idx = '0;
  logic [8:0]    cfg_wdata = '0;
  logic [3:0]    cpu_ack = '0, cpu_eoi = '0;
  logic [39:0]   cpu_eoi_id = '0;
  logic [3:0]    cpu_irq;
  logic [39:0]   cpu_ack_id;
  int errors = 0, checks = 0;

  irq_dist #(.NUM_SRC(NS)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int kind, input int idx, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_kind = 2'(kind); cfg_idx = 8'(idx); cfg_wdata = 9'(data);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic src(input int i, input int p, input int t, input int en);
    wr(0, i, (en << 8) | (t << 4) | p);
  endtask

  task automatic cpu(input int c, input int m, input int en);
    wr(1, c, (en << 4) | m);
  endtask

  task automatic pulse(input logic [NS-1:0] lines);
    @(negedge clk); irq_in = lines;
    @(negedge clk); irq_in = '0;
  endtask

  task automatic ack(input logic [3:0] which);
    @(negedge clk); cpu_ack = which;
    @(negedge clk); cpu_ack = '0;
  endtask

  function automatic int aid(input int c);
    return int'(cpu_ack_id[c*10 +: 10]);
  endfunction

  task automatic eoi(input int c, input int id);
    @(negedge clk); cpu_eoi = 4'(1 << c); cpu_eoi_id[c*10 +: 10] = 10'(id);
    @(negedge clk); cpu_eoi = '0;
  endtask

  task automatic t_reset;
    chk("R1 irq", cpu_irq, 0);
    for (int c = 0; c < 4; c++) chk("R1 ack_id", aid(c), 1023);
  endtask

  task automatic t_route;
    src(3, 5, 4'b0110, 1);
    pulse(16'h0008);
    chk("R2 R4 route", cpu_irq, 4'b0110);
    ack(4'b0010);
    chk("R5 R11 id", aid(1), 19);
    chk("R5 active hidden", cpu_irq, 0);
    pulse(16'h0008);
    chk("R6 edge while active", cpu_irq, 0);
    eoi(1, 19);
    chk("R6 idle after eoi", cpu_irq, 0);
    pulse(16'h0008);
    chk("R6 repend", cpu_irq, 4'b0110);
    ack(4'b0100);
    chk("R5 cpu2 id", aid(2), 19);
    eoi(2, 19);
    src(3, 5, 0, 0);
  endtask

  task automatic t_prio;
    src(5, 3, 4'b0001, 1);
    src(7, 3, 4'b0001, 1);
    src(2, 6, 4'b0001, 1);
    pulse(16'h00A4);
    ack(4'b0001);
    chk("R3 tie lower id", aid(0), 21);
    ack(4'b0001);
    chk("R3 second", aid(0), 23);
    ack(4'b0001);
    chk("R3 worst prio last", aid(0), 18);
    eoi(0, 21); eoi(0, 23); eoi(0, 18);
    ack(4'b0001);
    chk("R7 spurious", aid(0), 1023);
  endtask

  task automatic t_mask;
    src(4, 8, 4'b1000, 1);
    cpu(3, 8, 1);
    pulse(16'h0010);
    chk("R8 equal threshold masked", cpu_irq[3], 0);
    cpu(3, 9, 1);
    chk("R8 threshold above", cpu_irq[3], 1);
    cpu(3, 9, 0);
    chk("R8 iface disabled", cpu_irq[3], 0);
    ack(4'b1000);
    chk("R7 disabled ack spurious", aid(3), 1023);
    cpu(3, 15, 1);
    ack(4'b1000);
    chk("R12 R11 id", aid(3), 20);
    eoi(3, 20);
  endtask

  task automatic t_disabled;
    src(6, 1, 4'b0001, 0);
    pulse(16'h0040);
    chk("R2 disabled source", cpu_irq[0], 0);
    src(6, 1, 4'b0001, 1);
    chk("R2 edge not kept", cpu_irq[0], 0);
    src(6, 1, 4'b0001, 0);
  endtask

  task automatic t_ipi;
    wr(2, 0, (4'b1010 << 4) | 9);
    chk("R9 ipi list", cpu_irq, 4'b1010);
    ack(4'b0010);
    chk("R9 ipi id", aid(1), 9);
    chk("R9 only acker cleared", cpu_irq, 4'b1000);
    ack(4'b1000);
    chk("R9 ipi cpu3", aid(3), 9);
    chk("R9 all clear", cpu_irq, 0);
  endtask

  task automatic t_race;
    src(1, 2, 4'b0011, 1);
    pulse(16'h0002);
    chk("R10 both offered", cpu_irq[1:0], 2'b11);
    ack(4'b0011);
    chk("R10 winner", aid(0), 17);
    chk("R10 loser", aid(1), 1023);
    eoi(0, 17);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    for (int c = 0; c < 4; c++) cpu(c, 15, 1);
    t_route();
    t_prio();
    t_mask();
    t_disabled();
    t_ipi();
    t_race();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule